// File: doc/BRIEF.md
# Token-Gated Block Readout Slave

This block sits in a data acquisition module on a parallel backplane and answers a special block read issued by a readout controller. The controller holds the address strobe low with a dedicated address-modifier code, read direction and no interrupt acknowledge. A readout-enable token then travels from module to module. While the module holds the token it answers each data strobe with one 32-bit parameter word and an acknowledge. When it has nothing left to send, it hands the token on. Which module may drive the bus is set only by the token, so the block looks at no address lines.

The words come from a first-word-fall-through parameter buffer. While the strobes are high the block pops the word just sent, so the next word is already waiting when the next strobe arrives. If a converter is still busy and the buffer is empty, the block keeps the token and holds back its acknowledge. A control register sets two things. The route bit sends the token either to the downstream neighbour or to a shared open-drain return line. The test bit replaces the buffer with a sweep over every parameter index. Reset clears both bits.

Top module: `rdo_readout_slave`

## Requirements
- R1: A readout cycle exists only while `bus_as_n` is low, `bus_am` equals 6'h1B, and `bus_write_n` and `bus_iack_n` are both high. Outside such a cycle the block never asserts `dtack_n`, `data_oe` or any token output, and it pops no buffer word.
- R2: `data_oe` and the acknowledge (`dtack_n` low) appear only while `tok_in` is high and at least one data strobe is low. `data_oe` rises at least one clock before `dtack_n` falls. `data_out` is zero whenever `data_oe` is low.
- R3: Word layout: bits [15:0] hold the data value, bits [29:16] the 14-bit channel address, and bits [31:30] the qualifier. In normal mode the buffer words go out unchanged and in buffer order, and each word is popped exactly once.
- R4: `dtack_n` goes high within one clock of both data strobes being high. The word just sent is popped (`buf_rd`) while the acknowledge is released.
- R5: After the last word, the token is passed only once both strobes have been released after that word's acknowledge. No token output is active while `dtack_n` is low.
- R6: With an empty buffer and no busy converter, the token is passed no more than two clocks after `tok_in` is seen high inside a readout cycle.
- R7: While `conv_busy` is high and the buffer is empty, the block holds the token and withholds the acknowledge. A word that arrives is then sent, and the token is passed only once `conv_busy` falls.
- R8: A passed token stays active until `bus_as_n` goes high. It drops in the same cycle, without waiting for a clock edge.
- R9: Route bit 1 drives `tok_out` high. Route bit 0 drives `ret_pull_n` low, which pulls the open-drain return line. The two are never active together. Reset sets the route bit to 0. `ctl_load` writes `ctl_route_d` and `ctl_test_d` into the control register.
- R10: In test mode every readout returns N_PARAM words in index order i = 0..N_PARAM-1. Word i has channel address `chan_base + i`, data value i and qualifier 2'b00. The buffer and `conv_busy` are ignored. Reset clears test mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| bus_as_n | input | 1 | Address strobe, active low |
| bus_ds0_n | input | 1 | Data strobe 0, active low |
| bus_ds1_n | input | 1 | Data strobe 1, active low |
| bus_write_n | input | 1 | Write line, low means write |
| bus_iack_n | input | 1 | Interrupt acknowledge, active low |
| bus_am | input | 6 | Address-modifier code |
| dtack_n | output | 1 | Data acknowledge, active low |
| data_out | output | 32 | Parameter word to the data lines |
| data_oe | output | 1 | Output enable for the data lines |
| tok_in | input | 1 | Readout-enable token from upstream |
| tok_out | output | 1 | Push-pull token to downstream |
| ret_pull_n | output | 1 | Open-drain enable for the token return line, low pulls |
| buf_word | input | 32 | Head word of the parameter buffer |
| buf_empty | input | 1 | Parameter buffer empty |
| buf_rd | output | 1 | Pop the head word of the buffer |
| conv_busy | input | 1 | A converter is still converting |
| ctl_load | input | 1 | Write strobe for the control register |
| ctl_route_d | input | 1 | New route bit |
| ctl_test_d | input | 1 | New test-mode bit |
| chan_base | input | 14 | Programmed channel address of parameter index 0 |

## Verification
The main handshake runs many times with random burst lengths from one to eight words and random word contents. This shows that order, field layout and the one-pop-per-word rule hold at every length, including a single word, and it checks the acknowledge release timing on every transfer. Single-bit departures from the cycle qualifier (a wrong modifier code, a write, an interrupt acknowledge) and a strobe given without the token separate true readout recognition from plain strobe response. A busy converter with an empty buffer, a readout with no data, and a test-mode sweep with both the buffer and the busy flag active separate holding the token from passing it, and buffer data from generated data. A reset taken in the middle of the sequence confirms that both control bits return to zero.

// File: rtl/rdo_pkg.sv
package rdo_pkg;

  // Address-modifier code that marks a token readout cycle
  localparam logic [5:0] RDO_AM_CODE = 6'h1B;

  localparam int WORD_W  = 32;
  localparam int CHAN_W  = 14;
  localparam int VALUE_W = 16;
  localparam int QUAL_W  = 2;

  typedef struct packed {
    logic [QUAL_W-1:0]  qual;
    logic [CHAN_W-1:0]  chan;
    logic [VALUE_W-1:0] value;
  } rdo_word_t;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WAIT  = 3'd1,
    ST_DRIVE = 3'd2,
    ST_ACK   = 3'd3,
    ST_POP   = 3'd4,
    ST_PASS  = 3'd5
  } rdo_state_e;

endpackage

// File: rtl/rdo_cycle_decode.sv
module rdo_cycle_decode #(
  parameter logic [5:0] AM_CODE = rdo_pkg::RDO_AM_CODE
) (
  input  logic       as_n,
  input  logic       ds0_n,
  input  logic       ds1_n,
  input  logic       write_n,
  input  logic       iack_n,
  input  logic [5:0] am,
  output logic       cycle_ok,
  output logic       ds_any
);

  // Only AM, AS, WRITE and IACK qualify the cycle; address lines are not used.
  always_comb begin
    cycle_ok = !as_n && (am == AM_CODE) && write_n && iack_n;
    ds_any   = !ds0_n || !ds1_n;
  end

endmodule

// File: rtl/rdo_ctl_reg.sv
module rdo_ctl_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic route_d,
  input  logic test_d,
  output logic route_q,
  output logic test_q
);

  logic route_nx;
  logic test_nx;

  always_comb begin
    route_nx = route_q;
    test_nx  = test_q;
    if (load) begin
      route_nx = route_d;
      test_nx  = test_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q <= 1'b0;
      test_q  <= 1'b0;
    end else begin
      route_q <= route_nx;
      test_q  <= test_nx;
    end
  end

endmodule

// File: rtl/rdo_word_src.sv
module rdo_word_src #(
  parameter int N_PARAM = 16,
  parameter int CHAN_W  = rdo_pkg::CHAN_W,
  parameter int WORD_W  = rdo_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              test_mode,
  input  logic              cycle_ok,
  input  logic              advance,
  input  logic              buf_empty,
  input  logic [WORD_W-1:0] buf_word,
  input  logic              conv_busy,
  input  logic [CHAN_W-1:0] chan_base,
  output logic [WORD_W-1:0] word,
  output logic              have_word,
  output logic              done,
  output logic              buf_rd
);
  import rdo_pkg::*;

  localparam int IDX_W = $clog2(N_PARAM + 1);
  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(N_PARAM);

  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_d;
  logic             idx_en;
  logic             sweep_left;
  rdo_word_t        gen_word;

  assign sweep_left = (idx_q < IDX_END);

  // Index of the generated parameter; restarts outside a readout cycle.
  always_comb begin
    idx_d  = idx_q;
    idx_en = 1'b0;
    if (!cycle_ok) begin
      idx_d  = '0;
      idx_en = (idx_q != '0);
    end else if (advance && test_mode && sweep_left) begin
      idx_d  = idx_q + 1'b1;
      idx_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  always_comb begin
    gen_word.qual  = '0;
    gen_word.chan  = chan_base + CHAN_W'(idx_q);
    gen_word.value = VALUE_W'(idx_q);
  end

  always_comb begin
    if (test_mode) begin
      word      = gen_word;
      have_word = sweep_left;
      done      = !sweep_left;
      buf_rd    = 1'b0;
    end else begin
      word      = buf_word;
      have_word = !buf_empty;
      done      = buf_empty && !conv_busy;
      buf_rd    = advance;
    end
  end

endmodule

// File: rtl/rdo_handshake.sv
module rdo_handshake #(
  parameter int WORD_W = rdo_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cycle_ok,
  input  logic              tok_in,
  input  logic              ds_any,
  input  logic              have_word,
  input  logic              done,
  input  logic [WORD_W-1:0] word_in,
  output logic [WORD_W-1:0] data_q,
  output logic              data_oe,
  output logic              dtack_n,
  output logic              advance,
  output logic              passed
);
  import rdo_pkg::*;

  rdo_state_e        st_q;
  rdo_state_e        st_d;
  logic [WORD_W-1:0] data_d;
  logic              data_en;

  always_comb begin
    st_d    = st_q;
    data_d  = data_q;
    data_en = 1'b0;
    if (!cycle_ok) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE:  st_d = ST_WAIT;
        ST_WAIT: begin
          if (tok_in) begin
            if (done) begin
              st_d = ST_PASS;
            end else if (ds_any && have_word) begin
              st_d    = ST_DRIVE;
              data_d  = word_in;
              data_en = 1'b1;
            end
          end
        end
        ST_DRIVE: st_d = ST_ACK;
        ST_ACK:   if (!ds_any) st_d = ST_POP;
        ST_POP:   st_d = ST_WAIT;
        ST_PASS:  st_d = ST_PASS;
        default:  st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (data_en) begin
      data_q <= data_d;
    end
  end

  always_comb begin
    data_oe = (st_q == ST_DRIVE) || (st_q == ST_ACK);
    dtack_n = (st_q != ST_ACK);
    advance = (st_q == ST_POP);
    passed  = (st_q == ST_PASS);
  end

endmodule

// File: rtl/rdo_readout_slave.sv
module rdo_readout_slave #(
  parameter int N_PARAM = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_as_n,
  input  logic        bus_ds0_n,
  input  logic        bus_ds1_n,
  input  logic        bus_write_n,
  input  logic        bus_iack_n,
  input  logic [5:0]  bus_am,
  output logic        dtack_n,
  output logic [31:0] data_out,
  output logic        data_oe,
  input  logic        tok_in,
  output logic        tok_out,
  output logic        ret_pull_n,
  input  logic [31:0] buf_word,
  input  logic        buf_empty,
  output logic        buf_rd,
  input  logic        conv_busy,
  input  logic        ctl_load,
  input  logic        ctl_route_d,
  input  logic        ctl_test_d,
  input  logic [13:0] chan_base
);

  logic        cycle_ok;
  logic        ds_any;
  logic        route_q;
  logic        test_q;
  logic        advance;
  logic        have_word;
  logic        done;
  logic        passed;
  logic        held;
  logic [31:0] src_word;
  logic [31:0] data_q;

  rdo_cycle_decode u_decode (
    .as_n     (bus_as_n),
    .ds0_n    (bus_ds0_n),
    .ds1_n    (bus_ds1_n),
    .write_n  (bus_write_n),
    .iack_n   (bus_iack_n),
    .am       (bus_am),
    .cycle_ok (cycle_ok),
    .ds_any   (ds_any)
  );

  rdo_ctl_reg u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ctl_load),
    .route_d (ctl_route_d),
    .test_d  (ctl_test_d),
    .route_q (route_q),
    .test_q  (test_q)
  );

  rdo_word_src #(.N_PARAM(N_PARAM)) u_src (
    .clk       (clk),
    .rst_n     (rst_n),
    .test_mode (test_q),
    .cycle_ok  (cycle_ok),
    .advance   (advance),
    .buf_empty (buf_empty),
    .buf_word  (buf_word),
    .conv_busy (conv_busy),
    .chan_base (chan_base),
    .word      (src_word),
    .have_word (have_word),
    .done      (done),
    .buf_rd    (buf_rd)
  );

  rdo_handshake u_hs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cycle_ok  (cycle_ok),
    .tok_in    (tok_in),
    .ds_any    (ds_any),
    .have_word (have_word),
    .done      (done),
    .word_in   (src_word),
    .data_q    (data_q),
    .data_oe   (data_oe),
    .dtack_n   (dtack_n),
    .advance   (advance),
    .passed    (passed)
  );

  // Token release follows the address strobe without a clock edge.
  assign held       = passed && !bus_as_n;
  assign tok_out    = held && route_q;
  assign ret_pull_n = !(held && !route_q);
  assign data_out   = data_oe ? data_q : '0;

endmodule

// File: rtl/rdo_slave_chk.sv
module rdo_slave_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_as_n,
  input logic        bus_ds0_n,
  input logic        bus_ds1_n,
  input logic        bus_write_n,
  input logic        bus_iack_n,
  input logic [5:0]  bus_am,
  input logic        tok_in,
  input logic        dtack_n,
  input logic        data_oe,
  input logic [31:0] data_out,
  input logic        tok_out,
  input logic        ret_pull_n,
  input logic        buf_rd
);

  logic bus_qual;
  logic tok_any;
  assign bus_qual = !bus_as_n && (bus_am == 6'h1B) && bus_write_n && bus_iack_n;
  assign tok_any  = tok_out || !ret_pull_n;

  // R1
  no_resp_outside_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_qual) |-> (dtack_n && !data_oe && !buf_rd));

  // R2
  ack_needs_token_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dtack_n |-> (data_oe && tok_in));

  // R2
  data_before_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dtack_n) |-> $past(data_oe));

  // R2
  oe_start_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_oe) |-> $past(tok_in && !(bus_ds0_n && bus_ds1_n)));

  // R2
  idle_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !data_oe |-> (data_out == 32'h0));

  // R4
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dtack_n && bus_ds0_n && bus_ds1_n) |=> dtack_n);

  // R4
  pop_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_rd |-> dtack_n);

  // R5
  no_token_during_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dtack_n |-> !tok_any);

  // R8
  token_off_without_as_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_as_n |-> !tok_any);

  // R8
  token_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_any && !bus_as_n) |=> (tok_any || bus_as_n));

  // R9
  single_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tok_out && !ret_pull_n));

endmodule

bind rdo_readout_slave rdo_slave_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_as_n    (bus_as_n),
  .bus_ds0_n   (bus_ds0_n),
  .bus_ds1_n   (bus_ds1_n),
  .bus_write_n (bus_write_n),
  .bus_iack_n  (bus_iack_n),
  .bus_am      (bus_am),
  .tok_in      (tok_in),
  .dtack_n     (dtack_n),
  .data_oe     (data_oe),
  .data_out    (data_out),
  .tok_out     (tok_out),
  .ret_pull_n  (ret_pull_n),
  .buf_rd      (buf_rd)
);

// File: tb/rdo_readout_slave_bench.sv
module rdo_readout_slave_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N_PARAM    = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_as_n, bus_ds0_n, bus_ds1_n, bus_write_n, bus_iack_n;
  logic [5:0]  bus_am;
  logic        dtack_n, data_oe, tok_in, tok_out, ret_pull_n;
  logic [31:0] data_out;
  logic [31:0] buf_word;
  logic        buf_empty, buf_rd, conv_busy;
  logic        ctl_load, ctl_route_d, ctl_test_d;
  logic [13:0] chan_base;

  // Bench model of the first-word-fall-through buffer
  logic [31:0] mem [0:63];
  logic [5:0]  rd_ptr = 6'd0;
  logic [5:0]  wr_ptr = 6'd0;
  logic [31:0] exp_q [0:63];

  int total = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (buf_rd) rd_ptr <= rd_ptr + 6'd1;
  assign buf_empty = (rd_ptr == wr_ptr);
  assign buf_word  = mem[rd_ptr];

  rdo_readout_slave #(.N_PARAM(N_PARAM)) u_rdo_readout_slave (
    .clk(clk), .rst_n(rst_n), .bus_as_n(bus_as_n), .bus_ds0_n(bus_ds0_n),
    .bus_ds1_n(bus_ds1_n), .bus_write_n(bus_write_n), .bus_iack_n(bus_iack_n),
    .bus_am(bus_am), .dtack_n(dtack_n), .data_out(data_out), .data_oe(data_oe),
    .tok_in(tok_in), .tok_out(tok_out), .ret_pull_n(ret_pull_n),
    .buf_word(buf_word), .buf_empty(buf_empty), .buf_rd(buf_rd),
    .conv_busy(conv_busy), .ctl_load(ctl_load), .ctl_route_d(ctl_route_d),
    .ctl_test_d(ctl_test_d), .chan_base(chan_base)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] test_word(input int i, input logic [13:0] base);
    logic [13:0] a;
    a = base + 14'(i);
    return {2'b00, a, 16'(i)};
  endfunction

  function automatic bit tok_any();
    return tok_out || !ret_pull_n;
  endfunction

  task automatic push_word(input logic [31:0] w);
    mem[wr_ptr] = w;
    wr_ptr = wr_ptr + 6'd1;
  endtask

  task automatic ctl_write(input bit route, input bit test);
    ctl_route_d = route; ctl_test_d = test; ctl_load = 1'b1;
    tick();
    ctl_load = 1'b0;
  endtask

  task automatic open_cycle();
    bus_am = 6'h1B; bus_write_n = 1'b1; bus_iack_n = 1'b1; bus_as_n = 1'b0;
    tick();
  endtask

  task automatic close_cycle();
    bus_ds0_n = 1'b1; bus_ds1_n = 1'b1;
    tick();
    bus_as_n = 1'b1;
    #1;
    chk(!tok_any(), "R8 token drops with AS", {31'd0, tok_any()}, 32'd0);
    tick();
  endtask

  // Controller side of one readout: n words, then a strobe that only the token answers
  task automatic roc_read(input int n, input bit route);
    bit got;
    bit stray;
    open_cycle();
    for (int w = 0; w < n; w++) begin
      bus_ds0_n = 1'b0; bus_ds1_n = 1'b0; got = 1'b0;
      for (int k = 0; k < 40 && !got; k++) begin
        tick();
        if (!dtack_n) got = 1'b1;
      end
      chk(got, "R2 acknowledge for a waiting word", {31'd0, dtack_n}, 32'd0);
      chk(data_oe && data_out == exp_q[w], "R3 word content and order", data_out, exp_q[w]);
      bus_ds0_n = 1'b1; bus_ds1_n = 1'b1;
      tick();
      chk(dtack_n, "R4 acknowledge released in one clock", {31'd0, dtack_n}, 32'd1);
    end
    bus_ds0_n = 1'b0; bus_ds1_n = 1'b0; got = 1'b0; stray = 1'b0;
    for (int k = 0; k < 6; k++) begin
      tick();
      if (tok_any()) got = 1'b1;
      if (!dtack_n) stray = 1'b1;
    end
    chk(got && !stray, "R5 token passed after last word", {30'd0, stray, got}, 32'd1);
    chk(route ? (tok_out && ret_pull_n) : (!tok_out && !ret_pull_n),
        "R9 token routed by control bit", {30'd0, tok_out, ret_pull_n}, route ? 32'd3 : 32'd0);
    close_cycle();
  endtask

  task automatic neg_cycle(input logic [5:0] am, input bit wr_n, input bit iack_n,
                           input bit tin, input string tag);
    bit bad;
    bad = 1'b0;
    tok_in = tin;
    bus_am = am; bus_write_n = wr_n; bus_iack_n = iack_n; bus_as_n = 1'b0;
    bus_ds0_n = 1'b0; bus_ds1_n = 1'b0;
    for (int k = 0; k < 8; k++) begin
      tick();
      if (!dtack_n || data_oe || tok_any() || buf_rd) bad = 1'b1;
    end
    chk(!bad, tag, {31'd0, bad}, 32'd0);
    bus_ds0_n = 1'b1; bus_ds1_n = 1'b1; bus_as_n = 1'b1; tok_in = 1'b1;
    bus_am = 6'h1B; bus_write_n = 1'b1; bus_iack_n = 1'b1;
    tick();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    bit got;
    bit bad;
    int t;
    logic [31:0] w;
    void'($urandom(32'h0BAD_5EED));
    rst_n = 1'b0; bus_as_n = 1'b1; bus_ds0_n = 1'b1; bus_ds1_n = 1'b1;
    bus_write_n = 1'b1; bus_iack_n = 1'b1; bus_am = 6'h00; tok_in = 1'b1;
    conv_busy = 1'b0; ctl_load = 1'b0; ctl_route_d = 1'b0; ctl_test_d = 1'b0;
    chan_base = 14'h2A40;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    chk(dtack_n && !data_oe && data_out == 32'h0 && !tok_out && ret_pull_n && !buf_rd,
        "R1 idle outputs after reset", {dtack_n, data_oe, tok_out, ret_pull_n, buf_rd, 27'd0},
        {1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 27'd0});

    // Words waiting in the buffer while non-matching cycles run
    for (int i = 0; i < 2; i++) begin
      w = $urandom;
      push_word(w);
      exp_q[i] = w;
    end
    neg_cycle(6'h0B, 1'b1, 1'b1, 1'b1, "R1 other modifier code ignored");
    neg_cycle(6'h1B, 1'b0, 1'b1, 1'b1, "R1 write cycle ignored");
    neg_cycle(6'h1B, 1'b1, 1'b0, 1'b1, "R1 interrupt acknowledge ignored");
    neg_cycle(6'h1B, 1'b1, 1'b1, 1'b0, "R2 no response without token");

    // Route bit cleared by reset: token goes to return line
    roc_read(2, 1'b0);

    ctl_write(1'b1, 1'b0);

    // R6: nothing to send
    open_cycle();
    got = 1'b0; t = 0;
    for (int k = 0; k < 2 && !got; k++) begin
      tick(); t++;
      if (tok_out) got = 1'b1;
    end
    chk(got, "R6 empty module passes token at once", t, 32'd2);
    close_cycle();

    // Random bursts
    for (int r = 0; r < 10; r++) begin
      int n;
      n = 1 + int'($urandom % 8);
      for (int i = 0; i < n; i++) begin
        w = $urandom;
        push_word(w);
        exp_q[i] = w;
      end
      roc_read(n, 1'b1);
    end

    // R7: busy converter with empty buffer
    conv_busy = 1'b1;
    open_cycle();
    bus_ds0_n = 1'b0; bus_ds1_n = 1'b0; bad = 1'b0;
    for (int k = 0; k < 8; k++) begin
      tick();
      if (!dtack_n || tok_any()) bad = 1'b1;
    end
    chk(!bad, "R7 busy and empty holds token and acknowledge", {31'd0, bad}, 32'd0);
    w = $urandom;
    push_word(w);
    got = 1'b0;
    for (int k = 0; k < 10 && !got; k++) begin
      tick();
      if (!dtack_n) got = 1'b1;
    end
    chk(got && data_out == w, "R7 late word sent once available", data_out, w);
    bus_ds0_n = 1'b1; bus_ds1_n = 1'b1;
    tick();
    bus_ds0_n = 1'b0; bus_ds1_n = 1'b0; bad = 1'b0;
    for (int k = 0; k < 6; k++) begin
      tick();
      if (tok_any() || !dtack_n) bad = 1'b1;
    end
    chk(!bad, "R7 token held while converter busy", {31'd0, bad}, 32'd0);
    conv_busy = 1'b0;
    got = 1'b0;
    for (int k = 0; k < 4 && !got; k++) begin
      tick();
      if (tok_out) got = 1'b1;
    end
    chk(got, "R7 token passed once converter idle", {31'd0, got}, 32'd1);
    close_cycle();

    // R10: test sweep ignores a buffered word and a busy converter
    ctl_write(1'b1, 1'b1);
    w = $urandom;
    push_word(w);
    conv_busy = 1'b1;
    for (int i = 0; i < N_PARAM; i++) exp_q[i] = test_word(i, chan_base);
    roc_read(N_PARAM, 1'b1);
    chan_base = 14'h3FFC;
    for (int i = 0; i < N_PARAM; i++) exp_q[i] = test_word(i, chan_base);
    roc_read(N_PARAM, 1'b1);
    conv_busy = 1'b0;

    // Reset clears test mode and route bit; the held buffer word comes out
    rst_n = 1'b0;
    tick();
    rst_n = 1'b1;
    tick();
    exp_q[0] = w;
    roc_read(1, 1'b0);
    chk(buf_empty, "R10 buffer untouched by test sweep then drained", {31'd0, buf_empty}, 32'd1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule